// File: doc/BRIEF.md
# GPIO Pad Configuration Bank

This block holds one 32-bit configuration word for each of a parameterised number of general-purpose pins (128 by default). Software reaches it over a simple word-wide register bus with separate read and write strobes. Each word controls whether the pin drives, the level it drives, an input-disable control, a receive-mode field and an interrupt-select field. The word also reports the synchronised level on the pin input and whether the host owns the pin. The block drives `pin_out` and `pin_oe` from the stored words and samples `pin_in` through a two-stage synchroniser.

The configuration array is not at a fixed place. A pointer register at address zero publishes the byte offset `CFG_BASE`, and pin n's word sits at `CFG_BASE + 4*n`. Four read-only lock words (one bit per pin) follow the pointer. They are loaded from the `LOCK_INIT` parameter. A host-ownership mask `HOST_INIT` is also fixed at build time. A pin word accepts writes only when the pin is unlocked and owned by the host. Reads return data one cycle after the read strobe.

Top module: `gpio_pad_bank`

## Requirements
- R1: A read of address 0x000 returns `CFG_BASE` (default 0x100). Writes to it have no effect.
- R2: Lock word k at address 0x004+4k returns bit j equal to `LOCK_INIT[32k+j]`. Writes to it have no effect.
- R3: Pin n's word at `CFG_BASE+4n` stores written bits 23:22 (receive mode), 21:14 (interrupt select), 4 (input disable), 3 (output disable) and 0 (drive value). Bits 31:28, 26:24 and 13:5 read 0, and so does bit 2.
- R4: Bit 27 of pin n's word reads `HOST_INIT[n]` and cannot be written.
- R5: A write to the word of a pin with `LOCK_INIT[n]=1` is ignored, and the word keeps its value.
- R6: A write to the word of a pin with `HOST_INIT[n]=0` is ignored.
- R7: `pin_oe[n]` is the inverse of bit 3 and `pin_out[n]` equals bit 0. Both take the new value in the cycle after the write edge.
- R8: Bit 1 reads `pin_in[n]` through two flops. A level applied before edge A shows in a read captured at edge A+2 and not earlier.
- R9: After reset every word reads `{HOST_INIT[n] at bit 27, bit 23 set, bit 3 set}`, that is 0x08800008 for an owned pin, and `pin_oe` is all zero.
- R10: Reads of unmapped addresses (0x014 up to `CFG_BASE`, and `CFG_BASE+4*NUM_PINS` and above) return 0. Writes to them change nothing.
- R11: `bus_rdata` is loaded at the clock edge that samples `bus_rd`. It holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Drive value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |

## Verification
The properties assume that `bus_rd` and `bus_wr` are low while reset is held. They also assume that `CFG_BASE` lies word-aligned above the lock words, so that the unmapped gap the checker computes is the same region the decoder leaves empty. The stimulus keeps to this. It drives strobes only after reset is released and changes them only on falling edges, one access at a time. It keeps `pin_in` low except in the synchroniser test, so bit 1 of every other expected word is zero.

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank #(
  parameter int unsigned NUM_PINS  = 128,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CFG_BASE  = 32'h100,
  parameter logic [NUM_PINS-1:0] LOCK_INIT = '0,
  parameter logic [NUM_PINS-1:0] HOST_INIT = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  localparam int unsigned IDX_W     = $clog2(NUM_PINS);
  localparam int unsigned NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int unsigned PAD_W     = NUM_WORDS * 32;
  localparam int unsigned LOCK_LO   = 4;
  localparam int unsigned LOCK_END  = LOCK_LO + 4 * NUM_WORDS;
  localparam int unsigned CFG_END   = CFG_BASE + 4 * NUM_PINS;
  localparam logic [PAD_W-1:0] LOCK_PAD = PAD_W'(LOCK_INIT);

  logic [NUM_PINS-1:0] tx_q, txdis_q, rxdis_q;
  logic [1:0]          rxm_q  [NUM_PINS];
  logic [7:0]          isel_q [NUM_PINS];
  logic [NUM_PINS-1:0] sync1_q, sync2_q;

  logic [31:0]      a32, cfg_off, lock_off;
  logic             ptr_hit, lock_hit, cfg_hit, wr_ok;
  logic [IDX_W-1:0] idx;
  logic [31:0]      rd_word;

  assign a32      = 32'(bus_addr) & 32'hFFFF_FFFC;
  assign cfg_off  = a32 - CFG_BASE;
  assign lock_off = a32 - LOCK_LO;
  assign ptr_hit  = (a32 == 32'd0);
  assign lock_hit = (a32 >= LOCK_LO) && (a32 < LOCK_END);
  assign cfg_hit  = (a32 >= CFG_BASE) && (a32 < CFG_END);
  assign idx      = cfg_off[IDX_W+1:2];
  assign wr_ok    = bus_wr && cfg_hit && !LOCK_INIT[idx] && HOST_INIT[idx];

  assign pin_out = tx_q;
  assign pin_oe  = ~txdis_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= '0;
      txdis_q <= '1;
      rxdis_q <= '0;
      for (int i = 0; i < NUM_PINS; i++) begin
        rxm_q[i]  <= 2'd2;
        isel_q[i] <= 8'd0;
      end
    end else if (wr_ok) begin
      tx_q[idx]    <= bus_wdata[0];
      txdis_q[idx] <= bus_wdata[3];
      rxdis_q[idx] <= bus_wdata[4];
      isel_q[idx]  <= bus_wdata[21:14];
      rxm_q[idx]   <= bus_wdata[23:22];
    end
  end

  always_comb begin
    rd_word = '0;
    if (ptr_hit) begin
      rd_word = CFG_BASE;
    end else if (lock_hit) begin
      rd_word = LOCK_PAD[lock_off[31:2]*32 +: 32];
    end else if (cfg_hit) begin
      rd_word = {4'b0, HOST_INIT[idx], 3'b0, rxm_q[idx], isel_q[idx], 9'b0,
                 rxdis_q[idx], txdis_q[idx], 1'b0, sync2_q[idx], tx_q[idx]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

endmodule

module gpio_pad_bank_chk #(
  parameter int unsigned NUM_PINS  = 128,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CFG_BASE  = 32'h100,
  parameter logic [NUM_PINS-1:0] LOCK_INIT = '0,
  parameter logic [NUM_PINS-1:0] HOST_INIT = '1
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  localparam int unsigned GAP_LO  = 4 + 4 * ((NUM_PINS + 31) / 32);
  localparam int unsigned CFG_END = CFG_BASE + 4 * NUM_PINS;
  localparam logic [NUM_PINS-1:0] FROZEN = LOCK_INIT | ~HOST_INIT;

  logic [31:0] a;
  logic        in_gap, is_ptr;
  assign a      = 32'(bus_addr) & 32'hFFFF_FFFC;
  assign in_gap = ((a >= GAP_LO) && (a < CFG_BASE)) || (a >= CFG_END);
  assign is_ptr = (a == 32'd0);

  AST_PTR_VALUE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_rd) && $past(is_ptr)) |-> bus_rdata == CFG_BASE); // R1

  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_rd) && $past(in_gap)) |-> bus_rdata == 32'd0); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_rd)) |-> $stable(bus_rdata)); // R11

  AST_PINS_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_wr)) |-> ($stable(pin_oe) && $stable(pin_out))); // R7

  AST_FROZEN_PINS: assert property (@(posedge clk) disable iff (rst)
    ((pin_oe & FROZEN) == '0) && ((pin_out & FROZEN) == '0)); // R5

  AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0)); // R9
endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE),
  .LOCK_INIT(LOCK_INIT), .HOST_INIT(HOST_INIT)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_pad_bank_test.sv
module gpio_pad_bank_test;
  localparam int NP = 128;
  localparam logic [NP-1:0] LOCKS = 128'h80000000_00000000_00000100_00000020;
  localparam logic [NP-1:0] HOSTS = 128'hFFFFFFEF_FFFFFFFF_FFFFFFFF_FFFFFF7F;
  localparam int NV = 15;

  localparam logic [11:0] V_ADDR [NV] = '{12'h100, 12'h100, 12'h104, 12'h114, 12'h11C,
    12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h300, 12'h2FC, 12'h2F8, 12'h290};
  localparam logic [31:0] V_WDATA [NV] = '{32'hFFFFFFFF, 32'h00000000, 32'h00404001,
    32'hFFFFFFFF, 32'h00000000, 32'h00000055, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF,
    32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000002, 32'hFFFFFFFF};
  localparam logic [31:0] V_EXP [NV] = '{32'h08FFC019, 32'h08000000, 32'h08404001,
    32'h08800008, 32'h00800008, 32'h00000100, 32'h00000020, 32'h00000100, 32'h00000000,
    32'h80000000, 32'h00000000, 32'h00000000, 32'h08800008, 32'h08000000, 32'h00800008};
  localparam string V_REQ [NV] = '{"R3", "R3", "R3", "R5", "R6", "R1", "R2", "R2", "R2",
    "R2", "R10", "R10", "R5", "R4", "R6"};

  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  int n_chk = 0, n_bad = 0;
  logic [31:0] held;

  always #10 clk = ~clk;

  gpio_pad_bank #(.NUM_PINS(NP), .ADDR_W(12), .CFG_BASE(32'h100),
    .LOCK_INIT(LOCKS), .HOST_INIT(HOSTS)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1;
    @(posedge clk); @(negedge clk);
    bus_rd = 0; d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check("R9 oe", 32'(pin_oe == '0), 32'd1);
    rd(12'h10C, r); check("R9 owned", r, 32'h08800008);
    rd(12'h11C, r); check("R9 not owned", r, 32'h00800008);

    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_WDATA[i]);
      rd(V_ADDR[i], r);
      check(V_REQ[i], r, V_EXP[i]);
    end

    // R7 outputs follow pin1 (0x08404001) and pin0 (0x08000000)
    check("R7 oe1", 32'(pin_oe[1]), 32'd1);
    check("R7 out1", 32'(pin_out[1]), 32'd1);
    check("R7 oe0", 32'(pin_oe[0]), 32'd1);
    check("R7 out0", 32'(pin_out[0]), 32'd0);
    wr(12'h104, 32'h00000008);
    check("R7 oe1 off", 32'(pin_oe[1]), 32'd0);
    check("R7 out1 low", 32'(pin_out[1]), 32'd0);
    check("R5 locked oe", 32'(pin_oe[5]), 32'd0);
    check("R6 unowned oe", 32'(pin_oe[7]), 32'd0);

    // R8 two-flop latency on pin 9
    pin_in[9] = 1'b1;
    rd(12'h124, r); check("R8 edge A", r, 32'h08800008);
    rd(12'h124, r); check("R8 edge B", r, 32'h08800008);
    rd(12'h124, r); check("R8 edge C", r, 32'h0880000A);

    // R11 hold without read
    held = bus_rdata;
    wr(12'h128, 32'h00000001);
    @(negedge clk);
    check("R11 hold", bus_rdata, held);

    // R10 write to unmapped leaves neighbours alone
    wr(12'h300, 32'h00000000);
    rd(12'h2FC, r); check("R10 neighbour", r, 32'h08800008);
    check("R10 pin10 out", 32'(pin_out[10]), 32'd1);

    // R1 pointer survives writes
    rd(12'h000, r); check("R1 ptr", r, 32'h00000100);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule